// File: doc/BRIEF.md
# Four-Beat Wrapping Burst SRAM with Per-Beat Lane Masks

This block is a synchronous on-chip memory that moves data in bursts of four words. A requester gives one start address. The block then produces the other three addresses itself, one per clock cycle. Each word is 18 bits wide and is split into two 9-bit lanes.

On a write, each beat carries its own pair of active-low lane selects. A single burst can therefore update different lanes on different beats. On a read, the four stored words come back in the same order that a write burst from that start address would use. Only one burst is in flight at a time. A busy flag tells the requester when the next request can be taken.

Top module: `burst_sram`

## Requirements
- R1: The beat addresses of a burst keep the upper address bits of the start address. The two low bits count up from the start value and wrap modulo 4. A start offset of 1 gives offsets 1,2,3,0, and a start offset of 3 gives offsets 3,0,1,2.
- R2: `wr_lane_n` is active low. Bit 0 low stores `wr_data[8:0]` (lane 0) at the beat address. Bit 1 low stores `wr_data[17:9]` (lane 1). A lane whose select is high keeps its old content.
- R3: A beat with `wr_lane_n` = 2'b11 writes nothing, but the burst still moves on to the next address for the following beat.
- R4: Each beat uses only the lane selects and data present in that beat's cycle. The selects may differ on every beat of one burst.
- R5: A write burst takes beat 0 data in the cycle its request is accepted, and beats 1 to 3 in the three cycles that follow.
- R6: A read burst accepted at edge E0 presents the word of beat k on `rd_data` with `rd_valid` high, in the cycle after edge E0+k (k = 0..3). `rd_valid` is low at all other times.
- R7: After a request is accepted, `busy` is high for exactly three cycles. Requests seen while `busy` is high are ignored and change no memory content.
- R8: When both requests are present in an idle cycle, the write is taken and the read is dropped.
- R9: Reset clears `busy` and `rd_valid` but leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Start a write burst (taken only when idle) |
| rd_req | input | 1 | Start a read burst (taken only when idle, and only if no write request) |
| start_addr | input | ADDR_W | First word address of the burst |
| wr_data | input | 18 | Write data of the current beat |
| wr_lane_n | input | 2 | Active-low lane write selects of the current beat |
| busy | output | 1 | A burst is still running; new requests are ignored |
| rd_valid | output | 1 | `rd_data` holds a read beat |
| rd_data | output | 18 | Read data beat |

## Verification
The memory is first filled with full-lane bursts. It is then read back from all four start offsets of every row, which checks the wrap order on its own. Mixed bursts follow, in which the lane selects rotate through 00, 01, 10 and 11 inside one burst. In these bursts a lost lane, a wrongly written lane, a skipped address after an empty beat, or a select latched only once per burst each produces a different miscompare. Stray requests during a burst, a simultaneous read and write request, and a reset between write and read show whether busy gating, write priority and content retention hold.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int BEATS  = 4;
    localparam int OFS_W  = $clog2(BEATS);

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    // One beat of work handed from the sequencer to the storage.
    typedef struct packed {
        logic              wr_en;
        logic              rd_en;
        logic [LANES-1:0]  lane_we;
        logic [WORD_W-1:0] data;
    } beat_cmd_t;

    // Offset of a beat inside its 4-word block: linear count with wrap.
    function automatic logic [OFS_W-1:0] wrap_ofs(input logic [OFS_W-1:0] first,
                                                  input logic [OFS_W-1:0] beat);
        return first + beat;
    endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_lane_n,
    output logic              busy,
    output beat_cmd_t         cmd,
    output logic [ADDR_W-1:0] cmd_addr
);

    localparam logic [OFS_W-1:0] LAST_BEAT = OFS_W'(BEATS - 1);

    op_e               op_q;
    logic [ADDR_W-1:0] base_q;
    logic [OFS_W-1:0]  cnt_q;
    logic              idle;
    logic              take_wr;
    logic              take_rd;

    assign idle    = (op_q == OP_IDLE);
    assign take_wr = idle && wr_req;
    assign take_rd = idle && rd_req && !wr_req;
    assign busy    = !idle;

    always_comb begin
        cmd = '0;
        cmd.data = wr_data;
        if (idle) begin
            cmd_addr  = start_addr;
            cmd.wr_en = take_wr;
            cmd.rd_en = take_rd;
        end else begin
            cmd_addr  = {base_q[ADDR_W-1:OFS_W], wrap_ofs(base_q[OFS_W-1:0], cnt_q)};
            cmd.wr_en = (op_q == OP_WRITE);
            cmd.rd_en = (op_q == OP_READ);
        end
        cmd.lane_we = cmd.wr_en ? ~wr_lane_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (idle) begin
            if (take_wr || take_rd) begin
                op_q   <= take_wr ? OP_WRITE : OP_READ;
                base_q <= start_addr;
                cnt_q  <= OFS_W'(1);
            end
        end else begin
            cnt_q <= cnt_q + OFS_W'(1);
            if (cnt_q == LAST_BEAT) begin
                op_q <= OP_IDLE;
            end
        end
    end

endmodule

// File: rtl/lane_bank.sv
module lane_bank
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_cmd_t         cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);

    localparam int DEPTH = 2 ** ADDR_W;

    logic [WORD_W-1:0] rd_q;
    logic              vld_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (cmd.lane_we[l]) begin
                mem[cmd_addr] <= cmd.data[l*LANE_W +: LANE_W];
            end
            if (cmd.rd_en) begin
                rd_q[l*LANE_W +: LANE_W] <= mem[cmd_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= cmd.rd_en;
        end
    end

    assign rd_valid = vld_q;
    assign rd_data  = rd_q;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [17:0]       wr_data,
    input  logic [1:0]        wr_lane_n,
    output logic              busy,
    output logic              rd_valid,
    output logic [17:0]       rd_data
);

    beat_cmd_t         cmd;
    logic [ADDR_W-1:0] cmd_addr;

    burst_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .start_addr (start_addr),
        .wr_data    (wr_data),
        .wr_lane_n  (wr_lane_n),
        .busy       (busy),
        .cmd        (cmd),
        .cmd_addr   (cmd_addr)
    );

    lane_bank #(.ADDR_W(ADDR_W)) bank_i (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .cmd_addr (cmd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic clk,
    input logic rst,
    input logic wr_req,
    input logic rd_req,
    input logic busy,
    input logic rd_valid
);

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && (wr_req || rd_req)) |=> busy);

    assert_burst_len_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(busy, 2)) |=> !busy);

    assert_read_start_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && rd_req && !wr_req) |=> rd_valid);

    assert_valid_tail_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !busy) |-> $past(busy));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_req) |=> !rd_valid);

endmodule

bind burst_sram burst_sram_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .busy     (busy),
    .rd_valid (rd_valid)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

    localparam int AW    = 5;
    localparam int WORDS = 2 ** AW;
    localparam int ROWS  = WORDS / 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [17:0]   wr_data = '0;
    logic [1:0]    wr_lane_n = 2'b11;
    logic          busy;
    logic          rd_valid;
    logic [17:0]   rd_data;

    logic [17:0] ref_mem [WORDS];
    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    burst_sram #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .start_addr (start_addr),
        .wr_data    (wr_data),
        .wr_lane_n  (wr_lane_n),
        .busy       (busy),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] pattern(input int seed, input int k);
        return 18'((seed * 7919 + k * 1237 + 91) ^ (seed << 6));
    endfunction

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k);
        logic [1:0] lo;
        lo = a[1:0] + 2'(k);
        return {a[AW-1:2], lo};
    endfunction

    // mixed=1 rotates the selects through 00,01,10,11 inside the burst (R2, R3, R4).
    // stray=1 raises both requests during beats 1..3 (R7); both=1 adds a read
    // request to the accepting cycle (R8).
    task automatic do_write(input logic [AW-1:0] a, input int seed, input bit mixed,
                            input bit stray, input bit both);
        for (int k = 0; k < 4; k++) begin
            logic [17:0] d;
            logic [1:0]  m;
            logic [AW-1:0] ak;
            d  = pattern(seed, k);
            m  = mixed ? 2'((k + a[1:0] + seed) % 4) : 2'b00;
            ak = beat_addr(a, k);
            @(negedge clk);
            if (k == 0) begin
                wr_req = 1'b1; rd_req = both; start_addr = a;
            end else begin
                wr_req = stray; rd_req = stray; start_addr = ~a;
            end
            wr_data = d; wr_lane_n = m;
            for (int l = 0; l < 2; l++) begin
                if (!m[l]) ref_mem[ak][l*9 +: 9] = d[l*9 +: 9];
            end
            @(posedge clk);
            #1;
            if (k == 0) begin
                check(busy == 1'b1, "R7 busy after write accept", 32'(busy), 1);
                if (both) check(rd_valid == 1'b0, "R8 read dropped", 32'(rd_valid), 0);
            end
        end
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0; wr_lane_n = 2'b11;
        check(busy == 1'b0, "R7 busy low after 4 beats (R5)", 32'(busy), 0);
        check(rd_valid == 1'b0, "R7 stray read ignored", 32'(rd_valid), 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        rd_req = 1'b1; start_addr = a;
        @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] ak;
            ak = beat_addr(a, k);
            @(negedge clk);
            rd_req = 1'b0;
            check(rd_valid == 1'b1, "R6 rd_valid in beat", 32'(rd_valid), 1);
            check(rd_data == ref_mem[ak], tag, 32'(rd_data), 32'(ref_mem[ak]));
            check(busy == (k < 3), "R7 busy span on read", 32'(busy), 32'(k < 3));
            if (k < 3) @(posedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R9 busy clear after reset", 32'(busy), 0);
        check(rd_valid == 1'b0, "R9 rd_valid clear after reset", 32'(rd_valid), 0);

        // Fill every word with full-lane bursts.
        for (int r = 0; r < ROWS; r++) do_write(AW'(r * 4), 100 + r, 1'b0, 1'b0, 1'b0);
        // Read back from all four start offsets: wrap order.
        for (int r = 0; r < ROWS; r++)
            for (int o = 0; o < 4; o++) do_read(AW'(r * 4 + o), "R1 wrap order read");

        // Mixed per-beat masks from every start offset.
        for (int r = 0; r < ROWS; r++)
            for (int o = 0; o < 4; o++) begin
                do_write(AW'(r * 4 + o), 1 + r * 4 + o, 1'b1, (o == 2), 1'b0);
                do_read(AW'(r * 4 + o), "R2/R3/R4 masked burst");
            end

        // Both requests in one idle cycle.
        do_write(AW'(9), 555, 1'b1, 1'b0, 1'b1);
        do_read(AW'(9), "R8 write taken");

        // Reset keeps contents.
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(busy == 1'b0, "R9 busy clear after second reset", 32'(busy), 0);
        for (int r = 0; r < ROWS; r++) do_read(AW'(r * 4 + (r % 4)), "R9 contents kept (R5)");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule